// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This engine moves data between a host I/O data port and a local buffer RAM. It passes every item through a single holding latch. The host sees a read strobe, a write strobe and a ready line. When the latch is not in the right state, the ready line goes low and stretches the host cycle with wait states. On the memory side the engine uses a request/grant port. A higher-priority local DMA can own that port, and the engine waits for it.

Software first sets a start address, a byte count, a direction and a step size, then pulses `start`. In a remote read, the engine fetches one item into the latch. Each host read of the data port empties the latch, and that read is the signal to fetch the next item. In a remote write, each host write fills the latch. The engine then stores the item to memory before it accepts another host write. After each memory access the address goes up by the step and the count goes down by the step. When the count is used up, `done` pulses for one cycle and the engine goes idle.

The controller has five states:
- IDLE: waiting for `start`.
- RD_FETCH: the latch is empty and the engine is requesting a memory read.
- RD_HOLD: the latch is full and waiting for a host read.
- WR_WAIT: the latch is empty and waiting for a host write.
- WR_STORE: the latch is full and the engine is requesting a memory write.

The transitions are:
- IDLE to RD_FETCH or WR_WAIT on `start` with a non-zero count. A zero count pulses `done` and stays in IDLE.
- RD_FETCH to RD_HOLD on a grant.
- RD_HOLD to RD_FETCH on a host read, or to IDLE when the count is zero.
- WR_WAIT to WR_STORE on a host write.
- WR_STORE to WR_WAIT on a grant, or to IDLE when that grant was the last step.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are 0 and `host_rdy` is 1.
- R2: A `start` pulse loads `start_addr`, `byte_count`, `dir_wr` (1 = host to memory) and `word_mode`. In read direction the next cycle shows `mem_req`=1, `mem_we`=0 and `mem_addr`=`start_addr`.
- R3: In a remote read, a host read made while the latch is empty sees `host_rdy`=0 until the fetched item is latched. The accepted read returns the memory word from the current address on `host_rdata`.
- R4: Each accepted host read starts the next fetch, at the previous address plus the step.
- R5: In a remote write, a host write made while the latch is full sees `host_rdy`=0. The latched word is written to memory, and `mem_addr` and `mem_wdata` stay stable until the grant.
- R6: The step is 2 when `word_mode`=1 and 1 otherwise. The address rises by the step and the count falls by the step, stopping at 0 rather than going below it. A transfer therefore takes ceil(count/step) items.
- R7: When the count is used up, `done` is 1 for exactly one cycle and `busy` goes low. A `start` with `byte_count`=0 pulses `done` in the same cycle and does not start a transfer.
- R8: While `local_busy`=1, `mem_req` stays 0. The pending access goes ahead after `local_busy` falls.
- R9: Outside an active transfer, `host_rdy` stays 1 and host strobes cause no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| dir_wr | input | 1 | 1 = host to memory, 0 = memory to host |
| word_mode | input | 1 | 1 = two bytes per step |
| start_addr | input | AW | First buffer address |
| byte_count | input | CW | Bytes to move |
| host_rd | input | 1 | Host data-port read strobe |
| host_wr | input | 1 | Host data-port write strobe |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Latch contents to host |
| host_rdy | output | 1 | Low inserts host wait states |
| local_busy | input | 1 | Local DMA owns the memory |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with grant |
| mem_gnt | input | 1 | Memory grant |
| busy | output | 1 | Transfer active |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the state register is wrong, `host_rdy` shows it at once. It drops in a cycle where the latch is full, or it stays high while the latch is empty. Either way the host sees the wrong data on its first read, or a memory write of stale data appears in the write log on the next grant. An address or count error shows up as a wrong `mem_addr` on the next access. It also shows up as a `done` pulse one item early or late, which the per-transfer item counting catches within a single transfer.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FETCH,
        ST_RD_HOLD,
        ST_WR_WAIT,
        ST_WR_STORE
    } rdma_state_t;
endpackage

// File: rtl/rdma_ptr.sv
module rdma_ptr #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          word_in,
    input  logic [AW-1:0] addr_in,
    input  logic [CW-1:0] cnt_in,
    output logic [AW-1:0] addr,
    output logic          cnt_zero,
    output logic          cnt_last
);
    logic          word_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] step;

    assign step     = word_q ? CW'(2) : CW'(1);
    assign cnt_zero = (cnt == '0);
    assign cnt_last = (cnt <= step);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr   <= '0;
            cnt    <= '0;
            word_q <= 1'b0;
        end else if (load) begin
            addr   <= addr_in;
            cnt    <= cnt_in;
            word_q <= word_in;
        end else if (adv) begin
            addr <= addr + AW'(step);
            cnt  <= cnt_last ? '0 : cnt - step;
        end
    end

    // R6: without a load the remaining count never rises
    a_r6_cnt_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/rdma_fsm.sv
module rdma_fsm
    import rdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dir_wr,
    input  logic cnt_in_zero,
    input  logic host_rd,
    input  logic host_wr,
    input  logic local_busy,
    input  logic mem_gnt,
    input  logic cnt_zero,
    input  logic cnt_last,
    output logic load,
    output logic adv,
    output logic ld_mem,
    output logic ld_host,
    output logic mem_req,
    output logic mem_we,
    output logic host_rdy,
    output logic busy,
    output logic done
);
    rdma_state_t state, nxt;
    logic xfer;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        adv      = 1'b0;
        ld_mem   = 1'b0;
        ld_host  = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        host_rdy = 1'b1;
        done     = 1'b0;
        xfer     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (cnt_in_zero) done = 1'b1;
                    else             nxt  = dir_wr ? ST_WR_WAIT : ST_RD_FETCH;
                end
            end
            ST_RD_FETCH: begin
                mem_req  = !local_busy;
                xfer     = mem_req && mem_gnt;
                host_rdy = !host_rd;
                if (xfer) begin
                    ld_mem = 1'b1;
                    adv    = 1'b1;
                    nxt    = ST_RD_HOLD;
                end
            end
            ST_RD_HOLD: begin
                if (host_rd) begin
                    if (cnt_zero) begin
                        done = 1'b1;
                        nxt  = ST_IDLE;
                    end else begin
                        nxt = ST_RD_FETCH;
                    end
                end
            end
            ST_WR_WAIT: begin
                if (host_wr) begin
                    ld_host = 1'b1;
                    nxt     = ST_WR_STORE;
                end
            end
            ST_WR_STORE: begin
                mem_req  = !local_busy;
                mem_we   = 1'b1;
                xfer     = mem_req && mem_gnt;
                host_rdy = !host_wr;
                if (xfer) begin
                    adv = 1'b1;
                    if (cnt_last) begin
                        done = 1'b1;
                        nxt  = ST_IDLE;
                    end else begin
                        nxt = ST_WR_WAIT;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
        busy = (state != ST_IDLE);
    end

    // R7: after a completion pulse the engine is idle
    a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R9: idle engine never stalls the host
    a_r9_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> host_rdy);
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_wr,
    input  logic          word_mode,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] byte_count,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdy,
    input  logic          local_busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_gnt,
    output logic          busy,
    output logic          done
);
    logic          load, adv, ld_mem, ld_host, cnt_zero, cnt_last;
    logic [DW-1:0] latch_q;

    rdma_ptr #(.AW(AW), .CW(CW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .word_in  (word_mode),
        .addr_in  (start_addr),
        .cnt_in   (byte_count),
        .addr     (mem_addr),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last)
    );

    rdma_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dir_wr      (dir_wr),
        .cnt_in_zero (byte_count == '0),
        .host_rd     (host_rd),
        .host_wr     (host_wr),
        .local_busy  (local_busy),
        .mem_gnt     (mem_gnt),
        .cnt_zero    (cnt_zero),
        .cnt_last    (cnt_last),
        .load        (load),
        .adv         (adv),
        .ld_mem      (ld_mem),
        .ld_host     (ld_host),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .host_rdy    (host_rdy),
        .busy        (busy),
        .done        (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       latch_q <= '0;
        else if (ld_mem)  latch_q <= mem_rdata;
        else if (ld_host) latch_q <= host_wdata;
    end

    assign host_rdata = latch_q;
    assign mem_wdata  = latch_q;

    // R8: local DMA blocks every remote memory request
    a_r8_defer_local: assert property (@(posedge clk) disable iff (!rst_n)
        local_busy |-> !mem_req);
    // R5: a pending write keeps its address and data until granted
    a_r5_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_gnt) |=> ($stable(mem_wdata) && $stable(mem_addr)));
endmodule

// File: tb/rdma_port_engine_tb.sv
module rdma_port_engine_tb;
    typedef struct packed {
        logic        dir;
        logic        word;
        logic [15:0] addr;
        logic [15:0] cnt;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 16'h0100, 16'd4},
        '{1'b0, 1'b1, 16'h0200, 16'd6},
        '{1'b1, 1'b0, 16'h0300, 16'd3},
        '{1'b1, 1'b1, 16'h0400, 16'd5}
    };

    logic clk = 0, rst_n = 0;
    logic start = 0, dir_wr = 0, word_mode = 0;
    logic [15:0] start_addr = 0, byte_count = 0;
    logic host_rd = 0, host_wr = 0;
    logic [15:0] host_wdata = 0, host_rdata;
    logic host_rdy, local_busy = 0, mem_req, mem_we, mem_gnt, busy, done;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic gnt_en = 1;

    int nchk = 0, nerr = 0, done_cnt = 0, log_n = 0;
    logic [15:0] log_a [64];
    logic [15:0] log_d [64];
    bit finished = 0;

    always #5 clk = ~clk;

    function automatic logic [15:0] mem_fn(input logic [15:0] a);
        return {a[7:0] ^ 8'h3C, a[7:0] + 8'h11};
    endfunction

    assign mem_gnt   = mem_req & gnt_en;
    assign mem_rdata = mem_fn(mem_addr);

    rdma_port_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr),
        .word_mode(word_mode), .start_addr(start_addr), .byte_count(byte_count),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdy(host_rdy), .local_busy(local_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        if (done) done_cnt <= done_cnt + 1;
        if (mem_req && mem_gnt && mem_we && log_n < 64) begin
            log_a[log_n] <= mem_addr;
            log_d[log_n] <= mem_wdata;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    task automatic do_start(input logic d, input logic w, input logic [15:0] a, input logic [15:0] c);
        dir_wr = d; word_mode = w; start_addr = a; byte_count = c; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic host_read(output logic [15:0] data);
        host_rd = 1;
        for (int i = 0; i < 100; i++) begin
            #1;
            if (host_rdy) begin
                data = host_rdata;
                @(negedge clk);
                host_rd = 0;
                return;
            end
            @(negedge clk);
        end
        host_rd = 0;
        data = 'x;
        chk("R3 read stalled", 0, 1);
    endtask

    task automatic host_write(input logic [15:0] data);
        host_wr = 1; host_wdata = data;
        for (int i = 0; i < 100; i++) begin
            #1;
            if (host_rdy) begin
                @(negedge clk);
                host_wr = 0;
                return;
            end
            @(negedge clk);
        end
        host_wr = 0;
        chk("R5 write stalled", 0, 1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [15:0] d;
        int steps, d0, l0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 host_rdy", host_rdy, 1);
        @(negedge clk);

        // R9 strobes while idle
        l0 = log_n;
        host_rd = 1; host_wr = 1; host_wdata = 16'hDEAD;
        #1;
        chk("R9 rdy idle", host_rdy, 1);
        chk("R9 no req idle", mem_req, 0);
        @(negedge clk); @(negedge clk);
        host_rd = 0; host_wr = 0;
        chk("R9 no write idle", log_n, l0);
        chk("R9 still idle", busy, 0);

        // vector table: R2 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            steps = (VEC[v].cnt + (VEC[v].word ? 1 : 0)) / (VEC[v].word ? 2 : 1);
            d0 = done_cnt;
            l0 = log_n;
            do_start(VEC[v].dir, VEC[v].word, VEC[v].addr, VEC[v].cnt);
            for (int k = 0; k < steps; k++) begin
                if (!VEC[v].dir) begin
                    host_read(d);
                    chk("R4 R6 read data", d,
                        mem_fn(VEC[v].addr + 16'(k * (VEC[v].word ? 2 : 1))));
                end else begin
                    host_write(16'hB000 + 16'(v * 16 + k));
                end
            end
            wait_idle();
            chk("R7 done once", done_cnt, d0 + 1);
            chk("R7 idle", busy, 0);
            if (VEC[v].dir) begin
                chk("R6 write count", log_n, l0 + steps);
                for (int k = 0; k < steps; k++) begin
                    chk("R5 R6 write addr", log_a[l0 + k],
                        VEC[v].addr + 16'(k * (VEC[v].word ? 2 : 1)));
                    chk("R5 write data", log_d[l0 + k], 16'hB000 + 16'(v * 16 + k));
                end
            end
        end

        // R7 zero count
        d0 = done_cnt;
        dir_wr = 0; word_mode = 0; start_addr = 16'h0900; byte_count = 0; start = 1;
        #1;
        chk("R7 zero done", done, 1);
        @(negedge clk);
        start = 0;
        #1;
        chk("R7 zero no busy", busy, 0);
        chk("R7 zero no req", mem_req, 0);
        chk("R7 zero single", done_cnt, d0 + 1);
        @(negedge clk);

        // R2 R3 wait states on read
        gnt_en = 0;
        do_start(1'b0, 1'b0, 16'h0500, 16'd2);
        host_rd = 1;
        #1;
        chk("R2 req", mem_req, 1);
        chk("R2 we", mem_we, 0);
        chk("R2 addr", mem_addr, 16'h0500);
        chk("R3 rdy low", host_rdy, 0);
        repeat (3) @(negedge clk);
        #1;
        chk("R3 rdy still low", host_rdy, 0);
        gnt_en = 1;
        @(negedge clk);
        #1;
        chk("R3 rdy released", host_rdy, 1);
        chk("R3 data", host_rdata, mem_fn(16'h0500));
        @(negedge clk);
        host_rd = 0;
        host_read(d);
        chk("R4 second item", d, mem_fn(16'h0501));
        wait_idle();

        // R8 local DMA holds off
        local_busy = 1;
        do_start(1'b0, 1'b0, 16'h0600, 16'd1);
        repeat (4) begin
            #1;
            chk("R8 held", mem_req, 0);
            @(negedge clk);
        end
        local_busy = 0;
        #1;
        chk("R8 resumed", mem_req, 1);
        host_read(d);
        chk("R8 data", d, mem_fn(16'h0600));
        wait_idle();

        // R5 hold while latch full
        gnt_en = 0;
        l0 = log_n;
        do_start(1'b1, 1'b0, 16'h0700, 16'd3);
        host_write(16'h1111);
        host_wr = 1; host_wdata = 16'h2222;
        #1;
        chk("R5 rdy low", host_rdy, 0);
        chk("R5 wdata", mem_wdata, 16'h1111);
        chk("R5 waddr", mem_addr, 16'h0700);
        gnt_en = 1;
        @(negedge clk);
        #1;
        chk("R5 rdy released", host_rdy, 1);
        @(negedge clk);
        host_wr = 0;
        host_write(16'h3333);
        wait_idle();
        chk("R5 log n", log_n, l0 + 3);
        chk("R5 log d1", log_d[l0 + 1], 16'h2222);
        chk("R5 log a2", log_a[l0 + 2], 16'h0702);

        summary();
    end
endmodule